// File: doc/BRIEF.md
# Prioritized UART Interrupt Index Controller

This block gathers the event sources of a UART into one interrupt line and one index value. Sixteen sources arrive as single-cycle pulses from the receiver, the transmitter, the LIN counter, the RX line edge detectors and the DMA channels. Each pulse sets its own raw status bit. A seventeenth source, the receive timeout, is produced inside the block from the RX FIFO empty flag, a character-arrival strobe and a bit-period tick. A mask register chooses which pending bits may drive the CPU interrupt.

Software reads an index that names the most urgent pending, enabled source as a code from 0x01 (receive timeout, most urgent) to 0x11 (TX DMA done, least urgent). Reading it clears the source it names. A write-one-to-clear access removes any chosen set of sources. The receive timeout also clears by itself as soon as the RX FIFO is empty.

Top module: `uart_irq_index`

## Requirements
- R1: After reset the raw status, the mask, the index and the interrupt output are all zero.
- R2: A pulse on `evtPulse[j]` sets raw status bit j+1 (index code j+2) on the next clock edge, whatever the mask holds. Bit k of the raw status, mask and clear vectors always belongs to index code k+1.
- R3: `irqIdx` shows k+1 for the lowest k with raw bit k and mask bit k both set, and 0x00 when no such k exists. Code order, most urgent first: 0x01 timeout, 0x02 framing, 0x03 parity, 0x04 break, 0x05 overrun, 0x06 RX fall, 0x07 RX rise, 0x08 LIN capture 0, 0x09 LIN capture 1, 0x0A LIN overflow, 0x0B receive, 0x0C transmit, 0x0D end of transmission, 0x0E address match, 0x0F clear-to-send, 0x10 RX DMA done, 0x11 TX DMA done.
- R4: `irqOut` is high exactly when some raw bit and its mask bit are both set.
- R5: An index read (`idxRd`) clears the raw bit named by `irqIdx` in that cycle and no other; a read while `irqIdx` is 0x00 clears nothing.
- R6: A register write with `regSel`=1 clears every raw bit whose data bit is 1; bits written 0 keep their value.
- R7: When a source sets in the same cycle that a read, a clear write or FIFO drain clears it, the bit ends set.
- R8: While the RX FIFO is non-empty, a counter advances once per `bitTick` and restarts on every `rxCharStrobe`; when it reaches `toThresh` it sets raw bit 0. It holds at zero while the FIFO is empty, and `toThresh`=0 never raises the timeout.
- R9: Raw bit 0 clears on the edge after any cycle in which `rxFifoEmpty` is high.
- R10: A register write with `regSel`=0 loads the mask from `regWdata` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evtPulse | input | 16 | Event pulses, bit j maps to index code j+2 |
| rxFifoEmpty | input | 1 | RX FIFO empty level |
| rxCharStrobe | input | 1 | One pulse per received character |
| bitTick | input | 1 | One pulse per bit period |
| toThresh | input | 8 | Timeout length in bit periods, 0 disables |
| regWr | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the mask, 1 selects the clear register |
| regWdata | input | 17 | Write data |
| idxRd | input | 1 | Index read strobe |
| irqIdx | output | 5 | Code of the most urgent enabled pending source |
| irqOut | output | 1 | CPU interrupt request |
| rawStatus | output | 17 | Raw status bits |
| maskOut | output | 17 | Current mask |

## Verification
A wrong status bit shows at `rawStatus` on the very next edge, and through `irqIdx` and `irqOut` in the same cycle whenever its mask bit is set, so a cycle-by-cycle model catches a lost set or a stray clear at once. A timeout counter that drifts by one tick shows as bit 0 rising one bit period early or late, so the bench compares every cycle rather than waiting for the eventual flag. A priority fault only shows when two enabled sources overlap, which is why several sources are kept pending with varied masks.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 17;
  localparam int IDXW = $clog2(NSRC + 1);
  localparam int CNTW = 8;

  typedef struct packed {
    logic [NSRC-1:0] setVec;
    logic [NSRC-1:0] clrVec;
    logic            maskWe;
    logic [NSRC-1:0] maskData;
  } ctrlStrb_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-2:0] evtPulse,
  input  logic            rxFifoEmpty,
  input  logic            rxCharStrobe,
  input  logic            bitTick,
  input  logic [CNTW-1:0] toThresh,
  input  logic            regWr,
  input  logic            regSel,
  input  logic [NSRC-1:0] regWdata,
  input  logic            idxRd,
  input  logic [IDXW-1:0] curIdx,
  output ctrlStrb_t       strb
);
  logic [CNTW-1:0] toCnt;
  logic            toFire;
  logic [NSRC-1:0] rdClr;

  assign toFire = !rxCharStrobe && !rxFifoEmpty && bitTick &&
                  (toThresh != '0) && (toCnt == toThresh - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) toCnt <= '0;
    else if (rxCharStrobe || rxFifoEmpty) toCnt <= '0;
    else if (bitTick && toCnt < toThresh) toCnt <= toCnt + 1'b1;
  end

  always_comb begin
    rdClr = '0;
    for (int k = 0; k < NSRC; k++)
      if (idxRd && curIdx == IDXW'(k + 1)) rdClr[k] = 1'b1;
  end

  always_comb begin
    strb.setVec   = {evtPulse, toFire};
    strb.clrVec   = rdClr | ((regWr && regSel) ? regWdata : '0) |
                    {{(NSRC-1){1'b0}}, rxFifoEmpty};
    strb.maskWe   = regWr && !regSel;
    strb.maskData = regWdata;
  end

  // R8
  char_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxCharStrobe || rxFifoEmpty) |=> toCnt == '0);
  // R8
  no_fire_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (toThresh == '0) |-> !strb.setVec[0]);
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  ctrlStrb_t       strb,
  output logic [NSRC-1:0] rawStatus,
  output logic [NSRC-1:0] maskReg,
  output logic [IDXW-1:0] curIdx,
  output logic            irqOut
);
  logic [NSRC-1:0] pendEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rawStatus <= '0;
      maskReg   <= '0;
    end else begin
      rawStatus <= (rawStatus & ~strb.clrVec) | strb.setVec;
      if (strb.maskWe) maskReg <= strb.maskData;
    end
  end

  assign pendEn = rawStatus & maskReg;
  assign irqOut = |pendEn;

  always_comb begin
    curIdx = '0;
    for (int k = NSRC - 1; k >= 0; k--)
      if (pendEn[k]) curIdx = IDXW'(k + 1);
  end

  // R3
  idx_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curIdx != '0) |-> pendEn[curIdx - 1'b1]);
  // R4
  irq_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut == (curIdx != '0));
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strb.setVec) |=> ((rawStatus & $past(strb.setVec)) == $past(strb.setVec)));
endmodule

// File: rtl/uart_irq_index.sv
module uart_irq_index
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-2:0] evtPulse,
  input  logic            rxFifoEmpty,
  input  logic            rxCharStrobe,
  input  logic            bitTick,
  input  logic [CNTW-1:0] toThresh,
  input  logic            regWr,
  input  logic            regSel,
  input  logic [NSRC-1:0] regWdata,
  input  logic            idxRd,
  output logic [IDXW-1:0] irqIdx,
  output logic            irqOut,
  output logic [NSRC-1:0] rawStatus,
  output logic [NSRC-1:0] maskOut
);
  ctrlStrb_t strb;

  irq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evtPulse(evtPulse), .rxFifoEmpty(rxFifoEmpty),
    .rxCharStrobe(rxCharStrobe), .bitTick(bitTick), .toThresh(toThresh),
    .regWr(regWr), .regSel(regSel), .regWdata(regWdata), .idxRd(idxRd),
    .curIdx(irqIdx), .strb(strb)
  );

  irq_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rawStatus(rawStatus),
    .maskReg(maskOut), .curIdx(irqIdx), .irqOut(irqOut)
  );

  // R9
  drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxFifoEmpty |=> !rawStatus[0]);
  // R10
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regWr && !regSel) |=> maskOut == $past(regWdata));
endmodule

// File: tb/sim_uart_irq_index.sv
module sim_uart_irq_index;
  localparam int NS = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evtPulse = '0;
  logic        rxFifoEmpty = 1'b1, rxCharStrobe = 1'b0, bitTick = 1'b0;
  logic [7:0]  toThresh = '0;
  logic        regWr = 1'b0, regSel = 1'b0, idxRd = 1'b0;
  logic [16:0] regWdata = '0;
  logic [4:0]  irqIdx;
  logic        irqOut;
  logic [16:0] rawStatus, maskOut;

  int nChk = 0, nFail = 0;
  logic [16:0] mSt = '0, mMask = '0;
  int mCnt = 0;

  always #2 clk = ~clk;

  uart_irq_index u0 (.*);

  function automatic logic [4:0] expIdx(logic [16:0] st, logic [16:0] mk);
    for (int k = 0; k < NS; k++) if (st[k] && mk[k]) return 5'(k + 1);
    return 5'd0;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmpAll();
    chk(rawStatus == mSt, "R2 raw", rawStatus, mSt);
    chk(maskOut == mMask, "R10 mask", maskOut, mMask);
    chk(irqIdx == expIdx(mSt, mMask), "R3 idx", irqIdx, expIdx(mSt, mMask));
    chk(irqOut == ((mSt & mMask) != 0), "R4 irq", irqOut, (mSt & mMask) != 0);
  endtask

  // model one edge, then compare after it
  task automatic step();
    logic [16:0] clr, setv;
    int nCnt;
    bit fire;
    fire = !rxCharStrobe && !rxFifoEmpty && bitTick && toThresh != 0 &&
           mCnt == int'(toThresh) - 1;
    if (rxCharStrobe || rxFifoEmpty) nCnt = 0;
    else if (bitTick && mCnt < int'(toThresh)) nCnt = mCnt + 1;
    else nCnt = mCnt;
    clr = '0;
    if (idxRd && expIdx(mSt, mMask) != 0) clr[expIdx(mSt, mMask) - 1] = 1'b1;
    if (regWr && regSel) clr |= regWdata;
    if (rxFifoEmpty) clr[0] = 1'b1;
    setv = {evtPulse, fire};
    mSt = (mSt & ~clr) | setv;
    if (regWr && !regSel) mMask = regWdata;
    mCnt = nCnt;
    @(posedge clk); #1;
    cmpAll();
  endtask

  task automatic idle();
    evtPulse = '0; rxCharStrobe = 0; bitTick = 0; regWr = 0; idxRd = 0;
  endtask

  initial begin
    #200000;
    nFail++; nChk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #9 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk(rawStatus == 0 && maskOut == 0, "R1 regs", rawStatus, 0);
    chk(irqIdx == 0 && !irqOut, "R1 idx", irqIdx, 0);

    // R10 enable all, R2 set with/without mask
    regWr = 1; regSel = 0; regWdata = 17'h0FFFF; step(); idle();
    evtPulse = 16'h8001; step(); idle();
    chk(rawStatus[16] && rawStatus[1], "R2 masked set", rawStatus, 17'h10002);
    // R3 lowest code wins: bit1 -> code 2
    chk(irqIdx == 5'd2, "R3 priority", irqIdx, 2);
    // R5 read clears only reported
    idxRd = 1; step(); idle();
    chk(rawStatus == 17'h10000, "R5 read clear", rawStatus, 17'h10000);
    // R5 read with idx 0 (bit16 masked) clears nothing
    chk(irqIdx == 0, "R5 idx zero", irqIdx, 0);
    idxRd = 1; step(); idle();
    chk(rawStatus == 17'h10000, "R5 zero read", rawStatus, 17'h10000);
    // R6 zeros no effect, ones clear
    evtPulse = 16'h0030; step(); idle();
    regWr = 1; regSel = 1; regWdata = 17'h00040; step(); idle();
    chk(rawStatus == 17'h10020, "R6 w1c", rawStatus, 17'h10020);
    // R7 set wins over clear write
    evtPulse = 16'h0010; regWr = 1; regSel = 1; regWdata = 17'h00020; step(); idle();
    chk(rawStatus[5], "R7 set wins", rawStatus, 17'h10020);
    regWr = 1; regSel = 1; regWdata = '1; step(); idle();

    // R8 timeout of 3 ticks, reload on char
    toThresh = 8'd3; rxFifoEmpty = 0; step();
    bitTick = 1; step(); step(); bitTick = 0; rxCharStrobe = 1; step(); idle();
    bitTick = 1; step(); step();
    chk(!rawStatus[0], "R8 reload", rawStatus[0], 0);
    step(); idle();
    chk(rawStatus[0] && irqIdx == 1, "R8 timeout", irqIdx, 1);
    // R9 drain clears it
    rxFifoEmpty = 1; step();
    chk(!rawStatus[0], "R9 drain", rawStatus[0], 0);
    // R8 threshold 0 disables
    toThresh = 0; rxFifoEmpty = 0; bitTick = 1;
    for (int i = 0; i < 20; i++) step();
    idle();
    chk(!rawStatus[0], "R8 disabled", rawStatus[0], 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      idle();
      if ($urandom_range(0, 99) < 15) evtPulse = 16'(1 << $urandom_range(0, 15));
      if ($urandom_range(0, 99) < 3) evtPulse = 16'($urandom);
      if ($urandom_range(0, 99) < 5) rxFifoEmpty = ~rxFifoEmpty;
      rxCharStrobe = ($urandom_range(0, 99) < 4);
      bitTick = ($urandom_range(0, 99) < 40);
      if ($urandom_range(0, 199) == 0) toThresh = 8'($urandom_range(0, 6));
      idxRd = ($urandom_range(0, 99) < 10);
      if ($urandom_range(0, 99) < 4) begin
        regWr = 1; regSel = $urandom_range(0, 1); regWdata = 17'($urandom);
      end
      step();
    end
    idle();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule